// File: doc/BRIEF.md
# Two-Cycle Packed Decimal Adder/Subtractor

This block adds or subtracts two packed decimal operands, four bits per digit, and returns a packed decimal result with a decimal carry or borrow out. A one-cycle `start` pulse launches an operation. Exactly one clock later the block raises `done` for one cycle, and `y` and `cout` hold the new result.

The first cycle resolves every inter-digit carry. Each digit slice works out its outcome for both possible incoming carries: a biased sum for addition, or a plain binary difference for subtraction. The incoming carry then picks between the two. The second cycle corrects each digit by six where needed. This correction never touches a carry. A negative difference comes out in ten's complement form, with `cout` set.

Top module: `bcd_addsub_cs`

## Requirements
- R1: Digit k of `a`, `b` and `y` occupies bits 4k+3:4k, so digit 0 is in bits 3:0. With `sub`=0 the result is `y` = (a + b + cin) mod 10^DIGITS. `cout` is 1 exactly when a + b + cin ≥ 10^DIGITS.
- R2: During addition, each digit is added with a bias of six. A digit that produces no carry therefore holds a raw nibble of at least 6 before correction. Every result digit equals (a_k + b_k + c_k) mod 10.
- R3: Carries ripple across the full word. 44444445 + 55555555 gives y = 00000000 and cout = 1.
- R4: With `sub`=1 the result is `y` = (a − b − cin) mod 10^DIGITS. `cout` is 1 exactly when a < b + cin.
- R5: A negative difference yields the ten's complement of its magnitude. For example, 00000001 − 00000002 gives y = 99999999 and cout = 1.
- R6: `cin` acts as a borrow-in when subtracting. 00000000 − 00000000 with cin = 1 gives y = 99999999 and cout = 1.
- R7: If `start` is sampled at rising edge N, then `y`, `cout` and `done` update at edge N+1. `done` stays high for exactly one cycle.
- R8: A `start` sampled while an operation is in its first cycle is ignored. It produces no extra `done` and does not change the result.
- R9: `y` and `cout` hold their values in every cycle in which `done` is low.
- R10: A synchronous active-high `rst` clears `y`, `cout` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when the block is idle |
| sub | input | 1 | 1 = subtract, 0 = add |
| cin | input | 1 | Carry-in (add) or borrow-in (subtract) |
| a | input | 4*DIGITS | First packed decimal operand |
| b | input | 4*DIGITS | Second packed decimal operand |
| y | output | 4*DIGITS | Packed decimal result |
| cout | output | 1 | Decimal carry-out or borrow-out |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the block with the default DIGITS = 8. At that width a carry has to cross eight digit slices to reach the top. This brings the full-word ripple cases within reach: all-nines plus one, the 44444445 + 55555555 chain, and borrow chains that wrap a small difference around to 99999999. The reference model uses 64-bit integers, so eight digits keep every expected sum and difference exact, including the carry out of the top digit.

// File: rtl/bcd_as_pkg.sv
package bcd_as_pkg;
   localparam int DIGIT_W = 4;
   typedef logic [DIGIT_W-1:0] digit_t;
   localparam digit_t DEC_FIX = 4'd6;
endpackage

// File: rtl/bcd_digit_cs.sv
module bcd_digit_cs
   import bcd_as_pkg::*;
(
   input  digit_t a_d,
   input  digit_t b_d,
   input  logic   sub,
   output digit_t raw0,
   output digit_t raw1,
   output logic   co0,
   output logic   co1
);
   logic [5:0] s0, s1;
   logic [4:0] d0, d1;

   always_comb begin
      // biased sums: carry of a nibble equals the decimal carry of the digit
      s0 = {2'b00, a_d} + {2'b00, b_d} + {2'b00, DEC_FIX};
      s1 = s0 + 6'd1;
      // plain binary differences, bit 4 flags a borrow
      d0 = {1'b0, a_d} - {1'b0, b_d};
      d1 = d0 - 5'd1;
      if (sub) begin
         raw0 = d0[3:0];
         raw1 = d1[3:0];
         co0  = d0[4];
         co1  = d1[4];
      end else begin
         raw0 = s0[3:0];
         raw1 = s1[3:0];
         co0  = |s0[5:4];
         co1  = |s1[5:4];
      end
   end
endmodule

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
   import bcd_as_pkg::*;
(
   input  digit_t raw,
   input  logic   sub,
   input  logic   dc,
   output digit_t fixed
);
   logic adj;

   always_comb begin
      // add: correct digits without carry; subtract: correct digits with borrow
      adj   = sub ? dc : ~dc;
      fixed = adj ? digit_t'(raw - DEC_FIX) : raw;
   end
endmodule

// File: rtl/bcd_addsub_cs.sv
module bcd_addsub_cs
   import bcd_as_pkg::*;
#(
   parameter int DIGITS = 8,
   localparam int W = DIGIT_W * DIGITS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         sub,
   input  logic         cin,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         cout,
   output logic         done
);
   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("DIGITS must be at least 1");
      end
   endgenerate

   // ---------------- stage 1: carry-select chain ----------------
   logic [DIGITS-1:0][DIGIT_W-1:0] raw0_v, raw1_v, raw_sel;
   logic [DIGITS-1:0]              co0_v, co1_v;
   logic [DIGITS:0]                cy;

   logic                           s1_vld, s1_sub, s1_cout;
   logic [DIGITS-1:0][DIGIT_W-1:0] s1_raw;
   logic [DIGITS-1:0]              s1_dc;
   logic                           accept;

   assign cy[0]  = cin;
   assign accept = start & ~s1_vld;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
         bcd_digit_cs u_cs (
            .a_d  (a[DIGIT_W*i +: DIGIT_W]),
            .b_d  (b[DIGIT_W*i +: DIGIT_W]),
            .sub  (sub),
            .raw0 (raw0_v[i]),
            .raw1 (raw1_v[i]),
            .co0  (co0_v[i]),
            .co1  (co1_v[i])
         );
         assign cy[i+1]    = cy[i] ? co1_v[i]  : co0_v[i];
         assign raw_sel[i] = cy[i] ? raw1_v[i] : raw0_v[i];

         // R3: a carry for carry-in 0 implies a carry for carry-in 1
         p_sel_mono_r3: assert property (@(posedge clk) disable iff (rst)
            co0_v[i] |-> co1_v[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
      end else begin
         s1_vld <= accept;
      end
      if (accept) begin
         s1_sub  <= sub;
         s1_raw  <= raw_sel;
         s1_dc   <= cy[DIGITS:1];
         s1_cout <= cy[DIGITS];
      end
   end

   // ---------------- stage 2: per-digit correction ----------------
   logic [DIGITS-1:0][DIGIT_W-1:0] fix_v;

   generate
      for (genvar j = 0; j < DIGITS; j++) begin : g_fix
         bcd_digit_fix u_fix (
            .raw   (s1_raw[j]),
            .sub   (s1_sub),
            .dc    (s1_dc[j]),
            .fixed (fix_v[j])
         );

         // R2: an addition digit without carry saw the bias, so raw >= 6
         p_nocarry_biased_r2: assert property (@(posedge clk) disable iff (rst)
            (s1_vld && !s1_sub && !s1_dc[j]) |-> (s1_raw[j] >= DEC_FIX));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         y    <= '0;
         cout <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= s1_vld;
         if (s1_vld) begin
            y    <= fix_v;
            cout <= s1_cout;
         end
      end
   end

   // R7: a loaded first stage always completes on the next edge
   p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
      s1_vld |=> done);
   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R8: no new operation is taken while the first stage is busy
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
      s1_vld |=> !s1_vld);
   // R9: results change only together with done
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !done |-> ($stable(y) && $stable(cout)));
endmodule

// File: tb/bcd_addsub_cs_bench.sv
`timescale 1ns/1ps
module bcd_addsub_cs_bench;
   localparam int DIGITS = 8;
   localparam int W = 4 * DIGITS;
   localparam longint MODV = 64'd100000000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         sub = 1'b0;
   logic         cin = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [W-1:0] y;
   logic         cout;
   logic         done;

   int tests = 0;
   int fails = 0;

   typedef struct {
      logic [W-1:0] y;
      logic         c;
      string        tag;
   } exp_t;

   exp_t q[$];

   always #4 clk = ~clk;

   bcd_addsub_cs #(.DIGITS(DIGITS)) u_bcd_addsub_cs (
      .clk(clk), .rst(rst), .start(start), .sub(sub), .cin(cin),
      .a(a), .b(b), .y(y), .cout(cout), .done(done)
   );

   function automatic longint dec_of(logic [W-1:0] v);
      longint r = 0;
      for (int k = DIGITS - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
      return r;
   endfunction

   function automatic logic [W-1:0] bcd_of(longint v);
      logic [W-1:0] r = '0;
      longint t = v;
      for (int k = 0; k < DIGITS; k++) begin
         r[4*k +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one accepted operation, expected item pushed to the scoreboard
   task automatic drive(string tag, logic s, logic c, logic [W-1:0] x, logic [W-1:0] z);
      exp_t e;
      longint r;
      r = s ? dec_of(x) - dec_of(z) - longint'(c) : dec_of(x) + dec_of(z) + longint'(c);
      if (s) begin
         e.c = (r < 0);
         if (r < 0) r = r + MODV;
      end else begin
         e.c = (r >= MODV);
         r = r % MODV;
      end
      e.y = bcd_of(r);
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      start = 1'b1; sub = s; cin = c; a = x; b = z;
      @(negedge clk);
      start = 1'b0;
   endtask

   // monitor: pop and compare on every done
   always @(negedge clk) begin
      if (!rst && done) begin
         if (q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R8: unexpected done, actual y %h expected none", y);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, {cout, y}, {e.c, e.y});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset y/cout", {cout, y}, '0);
      check("R10 reset done", {{W{1'b0}}, done}, '0);
      rst = 1'b0;
      @(negedge clk);

      drive("R1 add basic",      1'b0, 1'b0, 32'h12345678, 32'h11111111);
      drive("R2 add digit carry",1'b0, 1'b0, 32'h00000097, 32'h00000086);
      drive("R1 add with cin",   1'b0, 1'b1, 32'h00000009, 32'h00000000);
      drive("R1 add overflow",   1'b0, 1'b0, 32'h99999999, 32'h00000001);
      drive("R3 full ripple",    1'b0, 1'b0, 32'h44444445, 32'h55555555);
      drive("R1 add zero",       1'b0, 1'b0, 32'h00000000, 32'h00000000);
      drive("R4 sub basic",      1'b1, 1'b0, 32'h50000000, 32'h00000001);
      drive("R4 sub equal",      1'b1, 1'b0, 32'h12345678, 32'h12345678);
      drive("R5 sub negative",   1'b1, 1'b0, 32'h00000001, 32'h00000002);
      drive("R5 sub negative 2", 1'b1, 1'b0, 32'h00001234, 32'h98765432);
      drive("R6 borrow-in",      1'b1, 1'b1, 32'h00000000, 32'h00000000);
      drive("R6 borrow-in mid",  1'b1, 1'b1, 32'h00010000, 32'h00000000);
      repeat (3) @(negedge clk);

      // R7: latency and single-cycle pulse
      begin
         exp_t e;
         e.y = 32'h00000579; e.c = 1'b0; e.tag = "R7 latency result";
         q.push_back(e);
         start = 1'b1; sub = 1'b0; cin = 1'b0; a = 32'h00000123; b = 32'h00000456;
         @(negedge clk);
         start = 1'b0;
         check("R7 done low after sampling edge", {{W{1'b0}}, done}, '0);
         @(negedge clk);
         check("R7 done high one edge later", {{W{1'b0}}, done}, 1);
         @(negedge clk);
         check("R7 done drops after one cycle", {{W{1'b0}}, done}, '0);
      end

      // R8/R9: start held high for two edges, second one ignored
      begin
         exp_t e;
         e.y = 32'h00000030; e.c = 1'b0; e.tag = "R8 first op";
         q.push_back(e);
         start = 1'b1; sub = 1'b0; cin = 1'b0; a = 32'h00000015; b = 32'h00000015;
         @(negedge clk);
         a = 32'h77777777; b = 32'h11111111; sub = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (4) @(negedge clk);
         check("R9 result held after ignored start", {cout, y}, {1'b0, 32'h00000030});
         check("R8 scoreboard drained", W'(q.size()), '0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule